// File: doc/BRIEF.md
# T1 Receive Error Tally

This block keeps running tallies of the error events seen on the receive side of a T1 line interface. It turns them into a few status bits that a host can sample whenever it likes. Each input is a one-cycle pulse from the upstream receive logic:

- a bipolar violation,
- a framing-bit pattern error (terminal or superframe alignment bits),
- a CRC error,
- a controlled slip of the elastic store.

A level input says whether extended-superframe mode is active. A one-cycle tick arrives once per millisecond.

The host reads the outputs as bits that change state after a fixed number of events, or as a small wrapping count. It works out the event rate by comparing two samples.

- The bipolar violation tally is a free-running counter. Its three top bits are exposed.
- Framing errors are gathered in groups of four. The toggle that marks each group is rate-limited, so it can never change twice within 96 ticks of the millisecond timebase. A group that completes during the hold-off is remembered and shown as soon as the hold-off ends.
- The CRC error count only advances in extended-superframe mode.
- The slip bit flips once per slip.

Top module: `t1_err_tally`

## Requirements
- R1: `o_bpv_bits` equals the number of bipolar violations since reset, divided by 64, modulo 8. So `o_bpv_bits[0]` changes every 64 violations, `o_bpv_bits[1]` every 128 and `o_bpv_bits[2]` every 256.
- R2: Framing errors are counted modulo 4. Each time the count wraps, one toggle of `o_frm_tgl` is requested. If no hold-off is running, that toggle appears on the same clock edge that takes the fourth error.
- R3: After any change of `o_frm_tgl`, no further change occurs until at least 96 `i_tick_1ms` pulses have been taken. A tick taken on the edge that makes a change does not count.
- R4: `o_crc_cnt` is a 3-bit count of CRC errors taken while `i_esf_mode` is 1. It wraps from 7 to 0. CRC errors that arrive while `i_esf_mode` is 0 leave it unchanged.
- R5: `o_slip_tgl` inverts once for every slip pulse.
- R6: A framing group that completes during the hold-off is not lost. Only one toggle is kept pending, however many groups complete. The pending toggle appears on the clock edge after the one that takes the 96th tick.
- R7: Events of different kinds in the same cycle are all counted on that cycle's edge. Each output reflects a pulse on the first clock edge that samples the pulse.
- R8: While `rst_n` is 0, all outputs are 0. Pulses on the first two clock edges after `rst_n` rises are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_bpv_pulse | input | 1 | One bipolar violation |
| i_frm_err_pulse | input | 1 | One framing-bit pattern error |
| i_crc_err_pulse | input | 1 | One CRC error |
| i_slip_pulse | input | 1 | One controlled slip |
| i_esf_mode | input | 1 | Extended-superframe mode active |
| i_tick_1ms | input | 1 | Millisecond timebase pulse |
| o_bpv_bits | output | 3 | Violation count bits for 64/128/256 |
| o_frm_tgl | output | 1 | Rate-limited framing group toggle |
| o_crc_cnt | output | 3 | Wrapping CRC error count |
| o_slip_tgl | output | 1 | Slip toggle |

## Verification
A wrong low-order bit in the violation or CRC counters does not show on `o_bpv_bits` until the next multiple of 64 violations. On `o_crc_cnt` it shows within eight CRC errors. A broken framing group counter or pending flag only shows when a group completes. A toggle can then be lost, doubled or released early. A faulty hold-off counter therefore needs a run of 96 ticks followed by one more cycle before the error is visible. The directed framing tests step through that exact window, checking at the last tick and on the edge after it.

// File: rtl/t1_err_pkg.sv
package t1_err_pkg;
  localparam int BPV_TOP_BITS = 3;
  typedef enum logic {FE_CLEAR = 1'b0, FE_PENDING = 1'b1} fe_pend_t;
endpackage

// File: rtl/t1_err_rst_sync.sv
module t1_err_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic run_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      run_n   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      run_n   <= stage_q;
    end
  end
endmodule

// File: rtl/t1_err_wrap_cnt.sv
module t1_err_wrap_cnt #(
  parameter int W     = 3,
  parameter int OUT_W = 3
) (
  input  logic             clk,
  input  logic             run_n,
  input  logic             inc,
  output logic [OUT_W-1:0] top
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_d;
  end

  assign top = cnt_q[W-1 -: OUT_W];
endmodule

// File: rtl/t1_err_frm_guard.sv
module t1_err_frm_guard
  import t1_err_pkg::*;
#(
  parameter int HOLD_TICKS = 96,
  parameter int GRP_W      = 2
) (
  input  logic clk,
  input  logic run_n,
  input  logic err,
  input  logic tick,
  output logic tgl
);
  localparam int HW = $clog2(HOLD_TICKS + 1);

  logic [GRP_W-1:0] grp_q, grp_d;
  logic [HW-1:0]    hold_q, hold_d;
  fe_pend_t         pend_q, pend_d;
  logic             tgl_d;
  logic             grp_full, idle, want, fire;

  always_comb begin
    grp_full = err && (grp_q == '1);
    idle     = (hold_q == '0);
    want     = grp_full || (pend_q == FE_PENDING);
    fire     = want && idle;
    grp_d    = err ? grp_q + 1'b1 : grp_q;
    tgl_d    = tgl ^ fire;
    if (fire)          pend_d = FE_CLEAR;
    else if (grp_full) pend_d = FE_PENDING;
    else               pend_d = pend_q;
    if (fire)               hold_d = HW'(HOLD_TICKS);
    else if (tick && !idle) hold_d = hold_q - 1'b1;
    else                    hold_d = hold_q;
  end

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) begin
      grp_q  <= '0;
      hold_q <= '0;
      pend_q <= FE_CLEAR;
      tgl    <= 1'b0;
    end else begin
      grp_q  <= grp_d;
      hold_q <= hold_d;
      pend_q <= pend_d;
      tgl    <= tgl_d;
    end
  end
endmodule

// File: rtl/t1_err_tally.sv
module t1_err_tally
  import t1_err_pkg::*;
#(
  parameter int BPV_W      = 9,
  parameter int CRC_W      = 3,
  parameter int FE_GRP_W   = 2,
  parameter int HOLD_TICKS = 96
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    i_bpv_pulse,
  input  logic                    i_frm_err_pulse,
  input  logic                    i_crc_err_pulse,
  input  logic                    i_slip_pulse,
  input  logic                    i_esf_mode,
  input  logic                    i_tick_1ms,
  output logic [BPV_TOP_BITS-1:0] o_bpv_bits,
  output logic                    o_frm_tgl,
  output logic [CRC_W-1:0]        o_crc_cnt,
  output logic                    o_slip_tgl
);
  logic run_n;
  logic crc_inc;

  assign crc_inc = i_crc_err_pulse & i_esf_mode;

  t1_err_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .run_n(run_n));

  t1_err_wrap_cnt #(.W(BPV_W), .OUT_W(BPV_TOP_BITS)) u_bpv (
    .clk(clk), .run_n(run_n), .inc(i_bpv_pulse), .top(o_bpv_bits));

  t1_err_wrap_cnt #(.W(CRC_W), .OUT_W(CRC_W)) u_crc (
    .clk(clk), .run_n(run_n), .inc(crc_inc), .top(o_crc_cnt));

  t1_err_wrap_cnt #(.W(1), .OUT_W(1)) u_slip (
    .clk(clk), .run_n(run_n), .inc(i_slip_pulse), .top(o_slip_tgl));

  t1_err_frm_guard #(.HOLD_TICKS(HOLD_TICKS), .GRP_W(FE_GRP_W)) u_frm (
    .clk(clk), .run_n(run_n), .err(i_frm_err_pulse), .tick(i_tick_1ms),
    .tgl(o_frm_tgl));
endmodule

// File: rtl/t1_err_tally_chk.sv
module t1_err_tally_chk #(
  parameter int HOLD_TICKS = 96,
  parameter int CRC_W      = 3
) (
  input logic             clk,
  input logic             run_n,
  input logic             i_bpv_pulse,
  input logic             i_slip_pulse,
  input logic             i_esf_mode,
  input logic             i_tick_1ms,
  input logic [2:0]       o_bpv_bits,
  input logic             o_frm_tgl,
  input logic [CRC_W-1:0] o_crc_cnt,
  input logic             o_slip_tgl
);
  localparam int GW = $clog2(HOLD_TICKS + 2);

  logic          prev_tgl, seen, chg;
  logic [GW-1:0] gap;

  assign chg = (o_frm_tgl != prev_tgl);

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) begin
      prev_tgl <= 1'b0;
      seen     <= 1'b0;
      gap      <= '0;
    end else begin
      prev_tgl <= o_frm_tgl;
      if (chg) begin
        seen <= 1'b1;
        gap  <= i_tick_1ms ? GW'(1) : GW'(0);
      end else if (i_tick_1ms && gap < GW'(HOLD_TICKS)) begin
        gap <= gap + 1'b1;
      end
    end
  end

  AST_BPV_LOW_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!run_n)
    (o_bpv_bits[0] != $past(o_bpv_bits[0])) |-> $past(i_bpv_pulse)); // R1
  AST_BPV_CARRY: assert property (@(posedge clk) disable iff (!run_n)
    (o_bpv_bits[1] != $past(o_bpv_bits[1])) |-> $fell(o_bpv_bits[0])); // R1
  AST_FRM_GAP: assert property (@(posedge clk) disable iff (!run_n)
    (chg && seen) |-> (gap >= GW'(HOLD_TICKS))); // R3
  AST_CRC_STEP: assert property (@(posedge clk) disable iff (!run_n)
    (o_crc_cnt != $past(o_crc_cnt)) |-> (o_crc_cnt == CRC_W'($past(o_crc_cnt) + 1'b1))); // R4
  AST_CRC_ESF_ONLY: assert property (@(posedge clk) disable iff (!run_n)
    !i_esf_mode |=> $stable(o_crc_cnt)); // R4
  AST_SLIP_FLIP: assert property (@(posedge clk) disable iff (!run_n)
    i_slip_pulse |=> (o_slip_tgl != $past(o_slip_tgl))); // R5
  AST_SLIP_QUIET: assert property (@(posedge clk) disable iff (!run_n)
    !i_slip_pulse |=> $stable(o_slip_tgl)); // R5
endmodule

bind t1_err_tally t1_err_tally_chk #(.HOLD_TICKS(HOLD_TICKS), .CRC_W(CRC_W)) u_chk (
  .clk(clk), .run_n(run_n), .i_bpv_pulse(i_bpv_pulse), .i_slip_pulse(i_slip_pulse),
  .i_esf_mode(i_esf_mode), .i_tick_1ms(i_tick_1ms), .o_bpv_bits(o_bpv_bits),
  .o_frm_tgl(o_frm_tgl), .o_crc_cnt(o_crc_cnt), .o_slip_tgl(o_slip_tgl));

// File: tb/tb_t1_err_tally.sv
module tb_t1_err_tally;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bpv = 1'b0, frm = 1'b0, crc = 1'b0, slip = 1'b0, esf = 1'b0, tick = 1'b0;
  logic [2:0] o_bpv_bits;
  logic       o_frm_tgl;
  logic [2:0] o_crc_cnt;
  logic       o_slip_tgl;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  t1_err_tally dut (
    .clk(clk), .rst_n(rst_n), .i_bpv_pulse(bpv), .i_frm_err_pulse(frm),
    .i_crc_err_pulse(crc), .i_slip_pulse(slip), .i_esf_mode(esf), .i_tick_1ms(tick),
    .o_bpv_bits(o_bpv_bits), .o_frm_tgl(o_frm_tgl), .o_crc_cnt(o_crc_cnt),
    .o_slip_tgl(o_slip_tgl));

  // Row layout: [20] bpv [19] frm [18] crc [17] slip [16] esf [15:8] reps
  //             [7:5] expected bpv bits [4] frm [3:1] crc [0] slip
  localparam int NV = 14;
  localparam logic [20:0] VEC [NV] = '{
    {5'b10000, 8'd63,  8'b000_0_000_0},  // R1 just below 64
    {5'b10000, 8'd1,   8'b001_0_000_0},  // R1 64
    {5'b10000, 8'd64,  8'b010_0_000_0},  // R1 128
    {5'b10000, 8'd128, 8'b100_0_000_0},  // R1 256
    {5'b10000, 8'd128, 8'b110_0_000_0},  // R1 384
    {5'b10000, 8'd128, 8'b000_0_000_0},  // R1 512 wraps
    {5'b00100, 8'd5,   8'b000_0_000_0},  // R4 ignored outside ESF
    {5'b00101, 8'd5,   8'b000_0_101_0},  // R4 counts in ESF
    {5'b00101, 8'd3,   8'b000_0_000_0},  // R4 wraps 7 to 0
    {5'b00010, 8'd1,   8'b000_0_000_1},  // R5
    {5'b00010, 8'd3,   8'b000_0_000_0},  // R5
    {5'b01000, 8'd3,   8'b000_0_000_0},  // R2 three errors, no toggle
    {5'b01000, 8'd1,   8'b000_1_000_0},  // R2 fourth error toggles at once
    {5'b10111, 8'd65,  8'b001_1_001_1}   // R7 simultaneous events
  };

  function automatic logic [7:0] outs();
    return {o_bpv_bits, o_frm_tgl, o_crc_cnt, o_slip_tgl};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic clear_in();
    bpv = 0; frm = 0; crc = 0; slip = 0; tick = 0;
  endtask

  task automatic frm_errs(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); frm = 1'b1;
    end
    @(negedge clk); frm = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #35;
    chk("R8 outputs zero in reset", outs(), 8'h00);
    @(negedge clk); rst_n = 1'b1;
    slip = 1'b1;                          // taken by the first edge, ignored
    @(negedge clk); slip = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 slip ignored right after release", outs(), 8'h00);

    for (int v = 0; v < NV; v++) begin
      for (int r = 0; r < int'(VEC[v][15:8]); r++) begin
        @(negedge clk);
        {bpv, frm, crc, slip, esf} = VEC[v][20:16];
      end
      @(negedge clk);
      clear_in();
      chk($sformatf("R1/R2/R4/R5/R7 vector %0d", v), outs(), VEC[v][7:0]);
    end
    esf = 1'b0;

    // Hold-off started on the last framing toggle; no ticks taken yet.
    frm_errs(4);
    chk("R3 group during hold-off held back", {7'd0, o_frm_tgl}, 8'd1);
    ticks(95);
    chk("R3 still held after 95 ticks", {7'd0, o_frm_tgl}, 8'd1);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    chk("R6 no change on 96th tick edge", {7'd0, o_frm_tgl}, 8'd1);
    @(negedge clk);
    chk("R6 pending toggle applied next edge", {7'd0, o_frm_tgl}, 8'd0);

    frm_errs(8);
    ticks(96);
    repeat (2) @(negedge clk);
    chk("R6 only one toggle kept pending", {7'd0, o_frm_tgl}, 8'd1);
    ticks(96);
    repeat (2) @(negedge clk);
    chk("R6 no second pending toggle", {7'd0, o_frm_tgl}, 8'd1);

    frm_errs(3);
    chk("R2 three errors after idle hold-off", {7'd0, o_frm_tgl}, 8'd1);
    frm_errs(1);
    chk("R2 fourth error toggles when idle", {7'd0, o_frm_tgl}, 8'd0);

    @(negedge clk); slip = 1'b1; crc = 1'b1; esf = 1'b1;
    @(negedge clk); clear_in();
    chk("R7 single cycle update", {o_crc_cnt, 4'd0, o_slip_tgl}, {3'd2, 4'd0, 1'b0});

    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R8 asynchronous clear", outs(), 8'h00);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    @(negedge clk); bpv = 1'b1;
    @(negedge clk); bpv = 1'b0; slip = 1'b1;
    @(negedge clk); slip = 1'b0;
    chk("R8 counting resumes after release", outs(), 8'b000_0_000_1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule